// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12). The field is built as a quadratic extension of GF(2^6), not as a polynomial-basis field. Each operand is cut into a 6-bit upper half and a 6-bit lower half. The result comes from four GF(64) products: three on the halves and one by a fixed constant. A second mode implements the "step by generator" map that a 12-bit Reed-Solomon code uses to build its power tables. That map sends zero to one and multiplies every other value by the fixed element 0xE01.

A combinational result is always available on its own port. The same value can also be taken through a one-stage output register with a valid/ready handshake. That register accepts a new operand pair in the same cycle that it hands off the previous result.

Top module: `gf4096_mul_unit`

## Requirements
- R1: The base field is GF(2) polynomials modulo x^6+x+1. During shift-and-add, a carry into bit 6 is folded back by XOR with 0x43. With both upper halves zero, the 12-bit result equals the 6-bit base-field product of the lower halves.
- R2: With ah/al = opA[11:6]/opA[5:0] and bh/bl likewise for opB, the upper half is (ah^al)*(bh^bl) ^ al*bl and the lower half is (ah*bh)*0x21 ^ al*bl. Every product here is in GF(64), and the result is {upper, lower}. Multiplication distributes over XOR.
- R3: Multiplying by 0x001 returns the other operand unchanged.
- R4: Multiplying by 0x000 returns 0x000.
- R5: Swapping opA and opB does not change the product.
- R6: With genMode = 1 and opA = 0, the result is 0x001.
- R7: With genMode = 1 and opA nonzero, the result is opA multiplied by 0xE01 under R2. opB has no effect on the result in this mode.
- R8: A pair accepted on a clock edge (inValid and inReady both high) appears on outData, with outValid high, right after that edge. With no new pair and outReady high, outValid falls after the next edge.
- R9: While outValid is high and outReady is low, inReady is low. outData and outValid then hold their values, and any offered pair is not taken.
- R10: With outValid, outReady and inValid all high, the old result is handed off and the new pair is loaded on the same edge, so throughput is one result per cycle.
- R11: combData always shows the result for the current inputs. The registered outData equals the combData seen in the cycle the pair was accepted.
- R12: After reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operand pair is offered |
| inReady | output | 1 | The block can take a pair this cycle |
| genMode | input | 1 | 1: generator step on opA; 0: opA times opB |
| opA | input | 12 | First operand |
| opB | input | 12 | Second operand (ignored in generator mode) |
| outValid | output | 1 | outData holds a result |
| outReady | input | 1 | Downstream takes the result this cycle |
| outData | output | 12 | Registered result |
| combData | output | 12 | Combinational result of the current inputs |

## Verification
Two events can fall on the same edge: handing off the held result and loading a new operand pair into the single output register. The bench provokes this with a back-to-back stream while outReady stays high. It checks after every edge that the result of the previous pair is present and that inReady never dropped. A stall-then-release sequence covers the other case. The bench offers a new pair while the output is blocked, then raises outReady. The held value must survive the stall, and the new product must appear exactly one edge after the release.

// File: rtl/gf4096_pkg.sv
package gf4096_pkg;
  localparam int BASE_W   = 6;
  localparam int FULL_W   = 2 * BASE_W;
  // x^6 + x + 1 including the x^6 term
  localparam logic [BASE_W:0]   BASE_POLY = 7'h43;
  // constant standing in for the inverse of the base-field generator
  localparam logic [BASE_W-1:0] EXT_CONST = 6'h21;
  // element used by the generator step
  localparam logic [FULL_W-1:0] GEN_CONST = 12'hE01;

  typedef struct packed {
    logic load;
  } ctlStrobes_t;
endpackage

// File: rtl/gf_base_mul.sv
module gf_base_mul #(
  parameter int W = 6,
  parameter logic [W:0] POLY = 7'h43
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  localparam logic [W-1:0] FOLD = POLY[W-1:0];

  logic [W-1:0] acc [0:W];
  logic [W-1:0] sh  [0:W-1];

  assign acc[0] = '0;
  assign sh[0]  = b;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign acc[i+1] = a[i] ? (acc[i] ^ sh[i]) : acc[i];
    if (i < W - 1) begin : g_shift
      assign sh[i+1] = sh[i][W-1] ? ({sh[i][W-2:0], 1'b0} ^ FOLD)
                                  : {sh[i][W-2:0], 1'b0};
    end
  end

  assign p = acc[W];
endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul #(
  parameter int W = 6,
  parameter logic [W:0]   POLY = 7'h43,
  parameter logic [W-1:0] EXT  = 6'h21
) (
  input  logic [2*W-1:0] a,
  input  logic [2*W-1:0] b,
  output logic [2*W-1:0] p
);
  logic [W-1:0] aHi, aLo, bHi, bLo;
  logic [W-1:0] sumProd, loProd, hiProd, hiScaled;

  assign aHi = a[2*W-1:W];
  assign aLo = a[W-1:0];
  assign bHi = b[2*W-1:W];
  assign bLo = b[W-1:0];

  gf_base_mul #(.W(W), .POLY(POLY)) u_mulSum (.a(aHi ^ aLo), .b(bHi ^ bLo), .p(sumProd));
  gf_base_mul #(.W(W), .POLY(POLY)) u_mulLo  (.a(aLo),       .b(bLo),       .p(loProd));
  gf_base_mul #(.W(W), .POLY(POLY)) u_mulHi  (.a(aHi),       .b(bHi),       .p(hiProd));
  gf_base_mul #(.W(W), .POLY(POLY)) u_mulK   (.a(hiProd),    .b(EXT),       .p(hiScaled));

  assign p = {sumProd ^ loProd, hiScaled ^ loProd};
endmodule

// File: rtl/gf_datapath.sv
module gf_datapath
  import gf4096_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              genMode,
  input  logic [FULL_W-1:0] opA,
  input  logic [FULL_W-1:0] opB,
  output logic [FULL_W-1:0] combOut,
  output logic [FULL_W-1:0] regOut
);
  logic [FULL_W-1:0] mulB, product;

  assign mulB = genMode ? GEN_CONST : opB;

  gf_tower_mul #(.W(BASE_W), .POLY(BASE_POLY), .EXT(EXT_CONST)) u_tower (
    .a(opA), .b(mulB), .p(product)
  );

  assign combOut = (genMode && opA == '0) ? FULL_W'(1) : product;

  always_ff @(posedge clk) begin
    if (!rstN)             regOut <= '0;
    else if (strobes.load) regOut <= combOut;
  end

  // R3: the unit element leaves the other operand unchanged
  a_r3_identity: assert property (@(posedge clk) disable iff (!rstN)
    (mulB == FULL_W'(1)) |-> (product == opA));
  // R4: zero annihilates
  a_r4_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mulB == '0) |-> (product == '0));
endmodule

// File: rtl/gf_ctrl.sv
module gf_ctrl
  import gf4096_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctlStrobes_t strobes
);
  if (REGISTERED) begin : g_reg
    logic validQ;
    assign inReady      = !validQ || outReady;
    assign strobes.load = inValid && inReady;
    assign outValid     = validQ;
    always_ff @(posedge clk) begin
      if (!rstN)             validQ <= 1'b0;
      else if (strobes.load) validQ <= 1'b1;
      else if (outReady)     validQ <= 1'b0;
    end
    // R8: a result leaves only when it is taken
    a_r8_drop_only_on_ready: assert property (@(posedge clk) disable iff (!rstN)
      $fell(outValid) |-> $past(outReady));
  end else begin : g_comb
    assign inReady      = outReady;
    assign outValid     = inValid;
    assign strobes.load = 1'b0;
  end
endmodule

// File: rtl/gf4096_mul_unit.sv
module gf4096_mul_unit
  import gf4096_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              genMode,
  input  logic [FULL_W-1:0] opA,
  input  logic [FULL_W-1:0] opB,
  output logic              outValid,
  input  logic              outReady,
  output logic [FULL_W-1:0] outData,
  output logic [FULL_W-1:0] combData
);
  ctlStrobes_t       strobes;
  logic [FULL_W-1:0] regOut;

  gf_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  gf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .genMode(genMode),
    .opA(opA), .opB(opB), .combOut(combData), .regOut(regOut)
  );

  if (REGISTERED) begin : g_out_reg
    assign outData = regOut;

    // R8: an accepted pair is presented after the edge
    a_r8_load_valid: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inReady) |=> outValid);
    // R9: a blocked result holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !outReady) |=> (outValid && $stable(outData)));
    // R9: no acceptance while blocked
    a_r9_stall: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !outReady) |-> !inReady);
    // R11: registered value matches the combinational one at acceptance
    a_r11_match: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inReady) |=> (outData == $past(combData)));
  end else begin : g_out_comb
    assign outData = combData;
  end
endmodule

// File: tb/gf4096_mul_unit_tb.sv
module gf4096_mul_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 32'h5EED_1234;

  logic clk = 1'b0;
  logic rstN, inValid, inReady, genMode, outValid, outReady;
  logic [11:0] opA, opB, outData, combData;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf4096_mul_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .genMode(genMode), .opA(opA), .opB(opB), .outValid(outValid),
    .outReady(outReady), .outData(outData), .combData(combData)
  );

  function automatic logic [5:0] refGf64(input logic [5:0] a, input logic [5:0] b);
    logic [6:0] bb;
    logic [5:0] c;
    logic [5:0] aa;
    c = 0; aa = a; bb = {1'b0, b};
    for (int i = 0; i < 6; i++) begin
      if (aa[0]) c = c ^ bb[5:0];
      aa = aa >> 1;
      bb = bb << 1;
      if (bb[6]) bb = bb ^ 7'h43;
    end
    return c;
  endfunction

  function automatic logic [11:0] refMul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hi, lo;
    hi = refGf64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ refGf64(a[5:0], b[5:0]);
    lo = refGf64(refGf64(a[11:6], b[11:6]), 6'h21) ^ refGf64(a[5:0], b[5:0]);
    return {hi, lo};
  endfunction

  function automatic logic [11:0] refGen(input logic [11:0] x);
    return (x == 0) ? 12'h001 : refMul(x, 12'hE01);
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic evalComb(input logic m, input logic [11:0] a, input logic [11:0] b,
                          output logic [11:0] r);
    genMode = m; opA = a; opB = b;
    #1;
    r = combData;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] r, r2, r3, a, b, c, expPrev;
    logic m;
    void'($urandom(SEED));
    rstN = 0; inValid = 0; outReady = 0; genMode = 0; opA = 0; opB = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 outValid", {11'd0, outValid}, 12'd0);
    chk("R12 inReady", {11'd0, inReady}, 12'd1);
    rstN = 1;
    @(negedge clk);

    // R1: low halves only give the base-field product
    evalComb(0, 12'h003, 12'h021, r); chk("R1 low-half", r, {6'd0, refGf64(6'h03, 6'h21)});
    evalComb(0, 12'h020, 12'h002, r); chk("R1 fold 0x43", r, 12'h003);
    evalComb(0, 12'h03F, 12'h03F, r); chk("R1 full half", r, {6'd0, refGf64(6'h3F, 6'h3F)});
    // R2: composition with high halves in play
    evalComb(0, 12'h040, 12'h040, r); chk("R2 high*high", r, refMul(12'h040, 12'h040));
    evalComb(0, 12'hFFF, 12'hABC, r); chk("R2 dense", r, refMul(12'hFFF, 12'hABC));
    // R3, R4
    evalComb(0, 12'h9A7, 12'h001, r); chk("R3 identity", r, 12'h9A7);
    evalComb(0, 12'h001, 12'h5C3, r); chk("R3 identity left", r, 12'h5C3);
    evalComb(0, 12'hD4E, 12'h000, r); chk("R4 zero", r, 12'h000);
    evalComb(0, 12'h000, 12'hFFF, r); chk("R4 zero left", r, 12'h000);
    // R6, R7
    evalComb(1, 12'h000, 12'h777, r); chk("R6 gen zero", r, 12'h001);
    evalComb(1, 12'h001, 12'h000, r); chk("R7 gen one", r, refMul(12'h001, 12'hE01));
    evalComb(1, 12'h3B5, 12'h000, r2);
    evalComb(1, 12'h3B5, 12'hFFF, r); chk("R7 opB ignored", r, r2);
    chk("R7 gen value", r, refGen(12'h3B5));

    // random combinational checks
    for (int i = 0; i < 200; i++) begin
      a = 12'($urandom); b = 12'($urandom); c = 12'($urandom);
      evalComb(0, a, b, r);  chk("R2 random", r, refMul(a, b));
      evalComb(0, b, a, r2); chk("R5 commute", r2, r);
      evalComb(0, a, b ^ c, r3);
      evalComb(0, a, c, r2); chk("R2 distributive", r3, r ^ r2);
      evalComb(1, a, b, r);  chk("R7 random gen", r, refGen(a));
    end

    // R8 / R10 / R11: back-to-back stream with outReady held high
    @(negedge clk);
    outReady = 1;
    expPrev = 0;
    for (int i = 0; i < 40; i++) begin
      if (i > 0) begin
        chk("R10 outValid stream", {11'd0, outValid}, 12'd1);
        chk("R8 stream data", outData, expPrev);
      end
      chk("R10 inReady stream", {11'd0, inReady}, 12'd1);
      m = (i % 5 == 0);
      a = (i == 10) ? 12'h000 : 12'($urandom); b = 12'($urandom);
      inValid = 1; genMode = m; opA = a; opB = b;
      #1;
      expPrev = m ? refGen(a) : refMul(a, b);
      chk("R11 comb at accept", combData, expPrev);
      @(negedge clk);
    end
    chk("R8 last data", outData, expPrev);
    inValid = 0;
    @(negedge clk);
    chk("R8 drains", {11'd0, outValid}, 12'd0);

    // R9: stall then release
    outReady = 0; inValid = 1; genMode = 0; opA = 12'h123; opB = 12'h456;
    @(negedge clk);
    chk("R8 stall load", outData, refMul(12'h123, 12'h456));
    chk("R9 inReady low", {11'd0, inReady}, 12'd0);
    opA = 12'hFED; opB = 12'h0B0;
    @(negedge clk);
    chk("R9 held data", outData, refMul(12'h123, 12'h456));
    chk("R9 held valid", {11'd0, outValid}, 12'd1);
    outReady = 1;
    #1;
    chk("R10 ready on release", {11'd0, inReady}, 12'd1);
    @(negedge clk);
    chk("R10 new after release", outData, refMul(12'hFED, 12'h0B0));
    inValid = 0;
    @(negedge clk);
    chk("R8 idle", {11'd0, outValid}, 12'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule